// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterized set of level-sensitive interrupt lines and turns them into two processor request outputs. One output is for normal requests and one is for fast requests. A third input, reserved for critical events, passes to its own output without any masking. Software reaches the block through a small register bus. That bus exposes:
- the synchronized line levels;
- an enable mask that changes only through set and clear aliases;
- a per-line steering register that picks the fast or the normal output;
- per-group priority levels;
- a read-only word naming the highest-priority enabled pending line.

Sources are split into equal, contiguous groups. Each group carries one programmable priority level. The winner is the pending line in the group with the highest level; if two groups tie, the lower group index wins. Inside the winning group, the lowest line index wins. Because every line is level-sensitive, software acknowledges a request in one of two ways: it clears the condition at the device, or it drops the line's enable bit through the clear alias.

The bus is a plain control port and has no back-pressure. A write takes effect on the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational: it is valid whenever `bus_sel` is high and `bus_wr` is low, and reads as zero otherwise.

Top module: `pic_top`

## Requirements
- R1: Address 0 (raw view) reads the source lines in bits [NSRC-1:0], regardless of enable or steering. It reflects a level two clock edges after the edge that samples it.
- R2: Address 1 reads the enable mask. Writing address 1 leaves the mask unchanged.
  - Writing address 2 sets every mask bit written as 1.
  - Writing address 3 clears every mask bit written as 1.
  - Bits written as 0 to address 2 or address 3 stay unchanged.
- R3: Address 5 reads raw AND enable AND NOT steer (the normal-request status). Address 6 reads raw AND enable AND steer (the fast-request status).
- R4: `irq_o` is high one edge after the normal-request status is non-zero, and low one edge after it is zero. A disabled line never raises an output.
- R5: Address 4 is the read/write steering register. A 1 sends that line to `fiq_o`, and a 0 sends it to `irq_o`. `fiq_o` follows the fast-request status with the same one-edge delay as in R4.
- R6: `nmi_o` equals `nmi_i` delayed by three clock edges, with no dependence on any register.
- R7: Address 7 reads bit 31 as a valid flag and bits [IDX_W-1:0] as a line index. All other bits read 0. When no line is both raw-high and enabled, the whole word reads 0.
- R8: Address 7 names the enabled pending line whose group has the highest level.
  - If groups tie on level, the lower group index wins.
  - Inside the winning group, the lowest line index wins.
  - Group g covers lines g*GSZ to g*GSZ+GSZ-1, where GSZ = NSRC/NGRP.
- R9: Address 8 is read/write. It holds LVL_W bits per group, with group g in bits [g*LVL_W +: LVL_W]. A larger value means a higher priority.
- R10: After reset the following are all zero: the enable mask, the steering register, the group levels, and the three outputs.
- R11: A source asserted before edge k, with its line enabled, raises its output after edge k+2. The output stays high for as long as the line stays high and enabled.
- R12: Addresses 9 to 15 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level-sensitive interrupt lines |
| nmi_i | input | 1 | Non-maskable request line |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| nmi_o | output | 1 | Non-maskable request out |

## Verification
The bound checker watches the following on every cycle:
- the two-edge path from the source pins to the raw view;
- the three-edge path on the non-maskable line;
- that the enable mask holds still unless a set or clear alias is written;
- that no output rises without an enabled pending line;
- that the reported winner is itself pending and is flagged valid exactly when something is pending.

Some behaviour can only be shown by the bench's scenarios. The bench compares the outputs against its model on every clock, and directed reads cover the rest:
- which line wins when group levels tie or differ, and the lowest-index choice inside a group;
- that a direct write to the mask and writes to unmapped addresses are ignored;
- the exact rise edge after a source asserts.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] ADDR_RAW   = 4'd0;
  localparam logic [AW-1:0] ADDR_EN    = 4'd1;
  localparam logic [AW-1:0] ADDR_ENSET = 4'd2;
  localparam logic [AW-1:0] ADDR_ENCLR = 4'd3;
  localparam logic [AW-1:0] ADDR_STEER = 4'd4;
  localparam logic [AW-1:0] ADDR_IRQST = 4'd5;
  localparam logic [AW-1:0] ADDR_FIQST = 4'd6;
  localparam logic [AW-1:0] ADDR_TOP   = 4'd7;
  localparam logic [AW-1:0] ADDR_GLVL  = 4'd8;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int NGRP  = 4,
  parameter int LVL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [NSRC-1:0]    en_o,
  output logic [NSRC-1:0]    steer_o,
  output logic [NGRP*LVL_W-1:0] lvl_o
);
  localparam int LW = NGRP * LVL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      steer_o <= '0;
      lvl_o   <= '0;
    end else if (wr_stb) begin
      case (wr_addr)
        ADDR_ENSET: en_o    <= en_o | wr_data[NSRC-1:0];
        ADDR_ENCLR: en_o    <= en_o & ~wr_data[NSRC-1:0];
        ADDR_STEER: steer_o <= wr_data[NSRC-1:0];
        ADDR_GLVL:  lvl_o   <= wr_data[LW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int NSRC  = 8,
  parameter int NGRP  = 4,
  parameter int LVL_W = 2,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]       pend_i,
  input  logic [NGRP*LVL_W-1:0] lvl_i,
  output logic                  valid_o,
  output logic [IDX_W-1:0]      idx_o
);
  localparam int GSZ = NSRC / NGRP;

  logic [NGRP-1:0] grp_any;

  for (genvar g = 0; g < NGRP; g++) begin : g_any
    assign grp_any[g] = |pend_i[g*GSZ +: GSZ];
  end

  int              best_g;
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    best_g   = 0;
    best_lvl = '0;
    valid_o  = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g] && (!valid_o || lvl_i[g*LVL_W +: LVL_W] > best_lvl)) begin
        valid_o  = 1'b1;
        best_g   = g;
        best_lvl = lvl_i[g*LVL_W +: LVL_W];
      end
    end
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (valid_o && (i / GSZ == best_g) && pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int NGRP  = 4,
  parameter int LVL_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            nmi_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            nmi_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int LW    = NGRP * LVL_W;

  logic [NSRC:0]   sync_q;
  logic [NSRC-1:0] raw, en, steer, pend, irq_stat, fiq_stat;
  logic [LW-1:0]   lvl;
  logic            nmi_s, top_valid;
  logic [IDX_W-1:0] top_idx;

  pic_sync #(.W(NSRC + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({nmi_i, src_i}), .q_o(sync_q)
  );
  assign raw   = sync_q[NSRC-1:0];
  assign nmi_s = sync_q[NSRC];

  pic_regfile #(.NSRC(NSRC), .NGRP(NGRP), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(bus_sel & bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .en_o(en), .steer_o(steer), .lvl_o(lvl)
  );

  assign pend     = raw & en;
  assign irq_stat = pend & ~steer;
  assign fiq_stat = pend & steer;

  pic_prio #(.NSRC(NSRC), .NGRP(NGRP), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend), .lvl_i(lvl), .valid_o(top_valid), .idx_o(top_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
      nmi_o <= nmi_s;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_RAW:   bus_rdata[NSRC-1:0] = raw;
        ADDR_EN:    bus_rdata[NSRC-1:0] = en;
        ADDR_STEER: bus_rdata[NSRC-1:0] = steer;
        ADDR_IRQST: bus_rdata[NSRC-1:0] = irq_stat;
        ADDR_FIQST: bus_rdata[NSRC-1:0] = fiq_stat;
        ADDR_TOP: begin
          bus_rdata[DW-1]      = top_valid;
          bus_rdata[IDX_W-1:0] = top_idx;
        end
        ADDR_GLVL:  bus_rdata[LW-1:0] = lvl;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_i,
  input logic             nmi_i,
  input logic             nmi_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [NSRC-1:0]  raw,
  input logic [NSRC-1:0]  en,
  input logic [NSRC-1:0]  steer,
  input logic             top_valid,
  input logic [IDX_W-1:0] top_idx,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr
);
  int unsigned cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else if (cyc < 8) cyc <= cyc + 1;
  end

  logic alias_wr;
  assign alias_wr = bus_sel && bus_wr && (bus_addr == ADDR_ENSET || bus_addr == ADDR_ENCLR);

  assert_raw_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2) |-> (raw == $past(src_i, 2)));

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_wr |=> $stable(en));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|(raw & en)) |-> (!irq_o && !fiq_o));

  assert_fiq_steered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|(raw & en & steer)));

  assert_nmi_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3) |-> (nmi_o == $past(nmi_i, 3)));

  assert_top_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid == (|(raw & en)));

  assert_top_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (raw[top_idx] && en[top_idx]));
endmodule

bind pic_top pic_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .nmi_i(nmi_i), .nmi_o(nmi_o),
  .irq_o(irq_o), .fiq_o(fiq_o), .raw(raw), .en(en), .steer(steer),
  .top_valid(top_valid), .top_idx(top_idx), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/sim_pic_top.sv
module sim_pic_top;
  localparam int NSRC = 8, NGRP = 4, LVL_W = 2, GSZ = NSRC / NGRP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic nmi_i = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o, nmi_o;

  always #10 clk = ~clk;

  pic_top #(.NSRC(NSRC), .NGRP(NGRP), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .nmi_i(nmi_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .nmi_o(nmi_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  logic [NSRC-1:0] m_en, m_steer;
  logic [7:0] m_lvl;
  logic [NSRC:0] hist[$];
  logic e_irq, e_fiq, e_nmi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_steer = '0; m_lvl = '0;
      hist = '{'0, '0};
      e_irq = 0; e_fiq = 0; e_nmi = 0;
    end else begin
      e_irq = |(hist[1][NSRC-1:0] & m_en & ~m_steer);
      e_fiq = |(hist[1][NSRC-1:0] & m_en & m_steer);
      e_nmi = hist[1][NSRC];
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          4'd2: m_en = m_en | bus_wdata[NSRC-1:0];
          4'd3: m_en = m_en & ~bus_wdata[NSRC-1:0];
          4'd4: m_steer = bus_wdata[NSRC-1:0];
          4'd8: m_lvl = bus_wdata[7:0];
          default: ;
        endcase
      end
      hist.push_front({nmi_i, src_i});
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [NSRC-1:0] raw;
    logic [31:0] r;
    int best, bestl;
    raw = hist[1][NSRC-1:0];
    r = '0;
    case (a)
      4'd0: r[NSRC-1:0] = raw;
      4'd1: r[NSRC-1:0] = m_en;
      4'd4: r[NSRC-1:0] = m_steer;
      4'd5: r[NSRC-1:0] = raw & m_en & ~m_steer;
      4'd6: r[NSRC-1:0] = raw & m_en & m_steer;
      4'd7: begin
        best = -1; bestl = -1;
        for (int i = 0; i < NSRC; i++)
          if (raw[i] && m_en[i] && int'(m_lvl[(i/GSZ)*LVL_W +: LVL_W]) > bestl) begin
            best = i; bestl = int'(m_lvl[(i/GSZ)*LVL_W +: LVL_W]);
          end
        if (best >= 0) r = 32'h8000_0000 | 32'(best);
      end
      4'd8: r[7:0] = m_lvl;
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq_o", 32'(irq_o), 32'(e_irq));
      chk("R5 fiq_o", 32'(fiq_o), 32'(e_fiq));
      chk("R6 nmi_o", 32'(nmi_o), 32'(e_nmi));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] lit, bit use_model, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, use_model ? m_read(a) : lit);
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R10 reset state
    rd(4'd1, 32'h0, 0, "R10 enable");
    rd(4'd4, 32'h0, 0, "R10 steer");
    rd(4'd8, 32'h0, 0, "R10 levels");
    rd(4'd7, 32'h0, 0, "R10 top");
    chk("R10 outputs", {29'd0, irq_o, fiq_o, nmi_o}, 32'h0);

    // R1 raw view while disabled
    src_i = 8'hA5; idle(4);
    rd(4'd0, 32'hA5, 0, "R1 raw");
    rd(4'd5, 32'h0, 0, "R3 irq status masked");
    chk("R4 disabled no irq", 32'(irq_o), 32'h0);

    // R2 aliases
    wr(4'd1, 32'hFF);
    rd(4'd1, 32'h0, 0, "R2 direct write ignored");
    wr(4'd2, 32'h0F);
    rd(4'd1, 32'h0F, 0, "R2 set alias");
    wr(4'd2, 32'h00);
    wr(4'd3, 32'h00);
    rd(4'd1, 32'h0F, 0, "R2 zero bits unchanged");
    idle(1);
    chk("R4 irq raised", 32'(irq_o), 32'h1);

    // R3/R5 steering
    wr(4'd4, 32'h05);
    rd(4'd4, 32'h05, 0, "R5 steer readback");
    rd(4'd5, 32'h00, 0, "R3 irq status");
    rd(4'd6, 32'h05, 0, "R3 fiq status");
    idle(1);
    chk("R5 fiq high", 32'(fiq_o), 32'h1);
    chk("R5 irq low", 32'(irq_o), 32'h0);
    rd(4'd7, 32'h8000_0000, 0, "R7 top idx0");

    // R8/R9 groups
    wr(4'd2, 32'hF0);
    wr(4'd8, 32'hF4);
    rd(4'd8, 32'hF4, 0, "R9 levels readback");
    rd(4'd7, 32'h8000_0005, 0, "R8 highest group tie lower");
    wr(4'd3, 32'h20);
    rd(4'd7, 32'h8000_0007, 0, "R8 next group");
    src_i = 8'hC0; idle(3);
    rd(4'd7, 32'h8000_0006, 0, "R8 lowest index in group");
    wr(4'd3, 32'hFF);
    rd(4'd7, 32'h0, 0, "R7 nothing pending");
    idle(1);
    chk("R4 all cleared", {30'd0, irq_o, fiq_o}, 32'h0);

    // R12 unmapped
    wr(4'd15, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0, 0, "R12 enable untouched");
    rd(4'd8, 32'hF4, 0, "R12 levels untouched");
    rd(4'd15, 32'h0, 0, "R12 read zero");

    // R6 nmi with everything masked
    nmi_i = 1; idle(4);
    chk("R6 nmi passes", 32'(nmi_o), 32'h1);
    nmi_i = 0; idle(4);
    chk("R6 nmi clears", 32'(nmi_o), 32'h0);

    // R11 latency and level hold
    wr(4'd4, 32'h00);
    src_i = '0;
    wr(4'd2, 32'hFF);
    idle(4);
    src_i = 8'h01;
    idle(1); chk("R11 edge1 low", 32'(irq_o), 32'h0);
    idle(1); chk("R11 edge2 low", 32'(irq_o), 32'h0);
    idle(1); chk("R11 edge3 high", 32'(irq_o), 32'h1);
    for (int k = 0; k < 6; k++) begin
      idle(1); chk("R11 held", 32'(irq_o), 32'h1);
    end
    src_i = '0; idle(3);
    chk("R11 released", 32'(irq_o), 32'h0);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin src_i = NSRC'($urandom); nmi_i = 1'($urandom); idle(1); end
        1: wr(4'($urandom_range(2, 3)), 32'($urandom));
        2: begin
          logic [3:0] a;
          case ($urandom_range(0, 3))
            0: a = 4'd1; 1: a = 4'd4; 2: a = 4'd8; default: a = 4'd12;
          endcase
          wr(a, $urandom);
        end
        default: rd(4'($urandom_range(0, 15)), 32'h0, 1, "R1 R3 R7 R8 R12 model read");
      endcase
    end
    idle(4);
    finish_run();
  end
endmodule